// File: doc/BRIEF.md
# Vertical-Blank Evasion Update Guard

This block decides when a batch of display register writes may begin so that the whole batch lands inside a single frame. It turns a fixed time budget into a number of scanlines using the pixel clock rate and the horizontal total of the current mode. From that it forms a forbidden band of lines that ends one line before vertical blanking starts. A requester raises `req` and is held off while the live scanline from the timing generator lies inside that band. Once the scanline leaves the band it receives `grant`.

The scanline conversion is done by a small sequential divider. It reruns whenever the pixel clock or horizontal total inputs change. A request that arrives during that recomputation waits for it to finish. If the band cannot be formed, because one of its bounds would be zero or negative, the request is refused. If the scanline stays in the band for one millisecond of block clock, the grant is issued anyway and a timeout flag is raised. The frame counter is sampled when the grant is issued and compared again when the requester signals `done`. A mismatch means the batch straddled a frame boundary, and a failure flag is raised.

Top module: `vblank_guard`

## Requirements
- R1: The band height in lines is ceil(BUDGET_US × pclk_khz / (1000 × htotal)), with BUDGET_US = 100 by default. When htotal is 0 the height is 1 line.
- R2: The band covers scanlines from (vstart − height) to (vstart − 1) inclusive. Here vstart is `vbl_start` in progressive mode.
- R3: When `interlaced` is 1, vstart is `vbl_start` halved and rounded up.
- R4: If (vstart − height) ≤ 0 or (vstart − 1) ≤ 0, an accepted request gets a one-cycle `refused` pulse one cycle after it is sampled. In that case `grant` stays low.
- R5: A request sampled while the scanline is outside the band gets `grant` two cycles after it is raised.
- R6: While the scanline is inside the band, `grant` is withheld. It rises on the edge after the scanline is seen outside the band.
- R7: If the scanline stays inside the band for CYC_PER_MS wait cycles, `grant` and `timeout_err` rise together, CYC_PER_MS + 1 cycles after the request. Otherwise `timeout_err` is 0 with the grant.
- R8: `grant` stays high until `done`. On the edge that samples `done`, `grant` falls and `atomic_fail` becomes 1 exactly when `frame_cnt` differs from its value at the granting edge. `atomic_fail` holds until the next accepted request.
- R9: After reset, `grant`, `refused`, `timeout_err` and `atomic_fail` are all 0.
- R10: A change of `pclk_khz` or `htotal` restarts the band computation. A request raised in the same cycle is decided with the new band.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pclk_khz | input | PCLK_W | Pixel clock rate in kHz |
| htotal | input | LINE_W | Horizontal total in pixels |
| vbl_start | input | LINE_W | First line of vertical blanking |
| interlaced | input | 1 | Interlaced mode flag |
| scanline | input | LINE_W | Current scanline from the timing generator |
| frame_cnt | input | FRAME_W | Frame counter from the timing generator |
| req | input | 1 | Level request to start an update batch |
| done | input | 1 | Update batch finished (sampled while granted) |
| grant | output | 1 | Update may proceed; held until done |
| refused | output | 1 | One-cycle pulse: band could not be formed |
| timeout_err | output | 1 | Grant was forced by the one-millisecond limit |
| atomic_fail | output | 1 | Frame counter changed between grant and done |

## Verification
The hardest situation to reach from the ports is a forced grant. The scanline must sit inside the band for the whole millisecond window, and the band itself depends on a divider result that the bench never sees directly. The bench therefore computes the band arithmetically for every configuration in a sweep of pixel clocks, horizontal totals, blanking starts and both scan modes. It parks the scanline on each band edge and on the lines just outside them. A reduced CYC_PER_MS parameter keeps each forced wait short, and one case moves the scanline out of the band partway through a wait. Further cases change the configuration and raise a request in the same cycle.

// File: rtl/vblank_guard.sv
module vblank_guard #(
  parameter int LINE_W     = 11,
  parameter int PCLK_W     = 18,
  parameter int FRAME_W    = 16,
  parameter int BUDGET_US  = 100,
  parameter int CYC_PER_MS = 100000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PCLK_W-1:0]  pclk_khz,
  input  logic [LINE_W-1:0]  htotal,
  input  logic [LINE_W-1:0]  vbl_start,
  input  logic               interlaced,
  input  logic [LINE_W-1:0]  scanline,
  input  logic [FRAME_W-1:0] frame_cnt,
  input  logic               req,
  input  logic               done,
  output logic               grant,
  output logic               refused,
  output logic               timeout_err,
  output logic               atomic_fail
);
  localparam int NW = PCLK_W + $clog2(BUDGET_US + 1);
  localparam int DW = LINE_W + 10;
  localparam int QW = NW + 1;
  localparam int CW = $clog2(NW + 1);
  localparam int TW = $clog2(CYC_PER_MS + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_HOLD} st_t;
  st_t st;

  logic [PCLK_W-1:0]  pclk_q;
  logic [LINE_W-1:0]  ht_q;
  logic               seen, dbusy;
  logic [NW-1:0]      dq;
  logic [DW-1:0]      rem;
  logic [CW-1:0]      dcnt;
  logic [QW-1:0]      lines;
  logic [TW-1:0]      tmr;
  logic [FRAME_W-1:0] cap;

  wire [NW-1:0] num  = NW'(pclk_khz) * NW'(BUDGET_US);
  wire [DW-1:0] den  = DW'(htotal) * DW'(1000);
  wire [DW:0]   trial = {rem, dq[NW-1]};
  wire          ge   = trial >= {1'b0, den};
  wire [NW-1:0] dq_n = {dq[NW-2:0], ge};
  wire [DW-1:0] rem_n = ge ? DW'(trial - {1'b0, den}) : DW'(trial);
  wire          cfg_chg = !seen || pclk_khz != pclk_q || htotal != ht_q;
  wire          ready = !cfg_chg && !dbusy;

  wire [LINE_W:0]   vb_half = ({1'b0, vbl_start} + (LINE_W+1)'(1)) >> 1;
  wire [LINE_W-1:0] vs      = interlaced ? LINE_W'(vb_half) : vbl_start;
  wire              win_ok  = vs > LINE_W'(1) && QW'(vs) > lines;
  wire [LINE_W-1:0] win_min = vs - LINE_W'(lines);
  wire [LINE_W-1:0] win_max = vs - LINE_W'(1);
  wire              in_win  = scanline >= win_min && scanline <= win_max;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 1'b0; dbusy <= 1'b0; pclk_q <= '0; ht_q <= '0;
      dq <= '0; rem <= '0; dcnt <= '0; lines <= QW'(1);
    end else if (cfg_chg) begin
      seen <= 1'b1; pclk_q <= pclk_khz; ht_q <= htotal;
      dq <= num; rem <= '0; dcnt <= '0;
      dbusy <= htotal != '0;
      if (htotal == '0) lines <= QW'(1);
    end else if (dbusy) begin
      dq <= dq_n; rem <= rem_n; dcnt <= dcnt + CW'(1);
      if (dcnt == CW'(NW - 1)) begin
        dbusy <= 1'b0;
        lines <= QW'(dq_n) + QW'(rem_n != '0);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; grant <= 1'b0; refused <= 1'b0;
      timeout_err <= 1'b0; atomic_fail <= 1'b0; tmr <= '0; cap <= '0;
    end else begin
      refused <= 1'b0;
      case (st)
        S_IDLE: if (req && ready) begin
          if (!win_ok) refused <= 1'b1;
          else begin
            st <= S_WAIT; tmr <= '0;
            timeout_err <= 1'b0; atomic_fail <= 1'b0;
          end
        end
        S_WAIT: begin
          if (!in_win || tmr == TW'(CYC_PER_MS - 1)) begin
            grant <= 1'b1; cap <= frame_cnt; st <= S_HOLD;
            timeout_err <= in_win;
          end else tmr <= tmr + TW'(1);
        end
        S_HOLD: if (done) begin
          grant <= 1'b0; st <= S_IDLE;
          atomic_fail <= frame_cnt != cap;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module vblank_guard_chk #(parameter int LINE_W = 11) (
  input logic              clk,
  input logic              rst_n,
  input logic              grant,
  input logic              refused,
  input logic              timeout_err,
  input logic              atomic_fail,
  input logic              done,
  input logic [LINE_W-1:0] scanline,
  input logic [LINE_W-1:0] win_min,
  input logic [LINE_W-1:0] win_max
);
  a_r4_refuse_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(refused && grant));
  a_r6_grant_outside: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant) && !timeout_err |->
      ($past(scanline) < $past(win_min) || $past(scanline) > $past(win_max)));
  a_r7_timeout_with_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> $rose(grant));
  a_r8_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
    grant && !done |=> grant);
  a_r8_fail_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(atomic_fail) |-> $past(done) && $past(grant));
endmodule

bind vblank_guard vblank_guard_chk #(.LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .grant(grant), .refused(refused),
  .timeout_err(timeout_err), .atomic_fail(atomic_fail), .done(done),
  .scanline(scanline), .win_min(win_min), .win_max(win_max));

// File: tb/test_vblank_guard.sv
module test_vblank_guard;
  localparam int LW = 11, PW = 18, FW = 16, TO = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [PW-1:0] pclk_khz = '0;
  logic [LW-1:0] htotal = '0, vbl_start = '0, scanline = '0;
  logic interlaced = 1'b0, req = 1'b0, done = 1'b0;
  logic [FW-1:0] frame_cnt = '0;
  logic grant, refused, timeout_err, atomic_fail;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  vblank_guard #(.LINE_W(LW), .PCLK_W(PW), .FRAME_W(FW), .CYC_PER_MS(TO)) i_vblank_guard (
    .clk(clk), .rst_n(rst_n), .pclk_khz(pclk_khz), .htotal(htotal),
    .vbl_start(vbl_start), .interlaced(interlaced), .scanline(scanline),
    .frame_cnt(frame_cnt), .req(req), .done(done), .grant(grant),
    .refused(refused), .timeout_err(timeout_err), .atomic_fail(atomic_fail));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int band_lines(input int p, input int h);
    if (h == 0) return 1;
    return (100 * p + 1000 * h - 1) / (1000 * h);
  endfunction

  int mn, mx, vs, ok;
  string ctag;

  task automatic set_cfg(input int p, input int h, input int vb, input bit il);
    pclk_khz = PW'(p); htotal = LW'(h); vbl_start = LW'(vb); interlaced = il;
    vs = il ? (vb + 1) / 2 : vb;
    mn = vs - band_lines(p, h);
    mx = vs - 1;
    ok = (mn > 0 && mx > 0) ? 1 : 0;
    ctag = il ? "R3" : (h == 0 ? "R1" : "R2");
  endtask

  task automatic one_req(input int s, input bool_exact, input int flip, input bit chg);
    int n = 0;
    int inw = (s >= mn && s <= mx) ? 1 : 0;
    scanline = LW'(s);
    req = 1'b1;
    while (n < 400) begin
      @(negedge clk); n++;
      if (flip > 0 && n == flip) scanline = LW'(mx + 1);
      if (grant || refused) break;
    end
    req = 1'b0;
    if (!ok) begin
      chk("R4", "refused pulse", refused, 1);
      chk("R4", "no grant", grant, 0);
      if (bool_exact) chk("R4", "refuse latency", n, 1);
      @(negedge clk);
      chk("R4", "refused one cycle", refused, 0);
      return;
    end
    chk(ctag, "grant given", grant, 1);
    if (flip > 0) begin
      chk("R6", "grant after leaving band", n, flip + 1);
      chk("R6", "no timeout", timeout_err, 0);
    end else begin
      chk(ctag, "band membership", timeout_err, inw);
      if (bool_exact) begin
        if (inw) chk("R7", "forced grant latency", n, TO + 1);
        else chk("R5", "grant latency", n, 2);
      end
    end
    @(negedge clk);
    chk("R8", "grant held", grant, 1);
    if (chg) frame_cnt = frame_cnt + FW'(1);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk("R8", "grant released", grant, 0);
    chk("R8", "atomic flag", atomic_fail, int'(chg));
    @(negedge clk);
    chk("R8", "atomic flag held", atomic_fail, int'(chg));
  endtask

  int pl[4] = '{0, 9000, 25000, 148500};
  int hl[4] = '{0, 37, 800, 2000};
  int vl[5] = '{1, 3, 50, 525, 1000};

  initial begin
    int k = 0;
    repeat (3) @(negedge clk);
    chk("R9", "grant after reset", grant, 0);
    chk("R9", "refused after reset", refused, 0);
    chk("R9", "timeout after reset", timeout_err, 0);
    chk("R9", "atomic after reset", atomic_fail, 0);
    rst_n = 1'b1;
    foreach (pl[a]) foreach (hl[b]) foreach (vl[c]) for (int il = 0; il < 2; il++) begin
      set_cfg(pl[a], hl[b], vl[c], il[0]);
      repeat (40) @(negedge clk);
      one_req(0, 1, 0, k[0]); k++;
      if (ok) begin
        if (mn > 0) begin one_req(mn - 1, 1, 0, k[0]); k++; end
        one_req(mn, 1, 0, k[0]); k++;
        one_req(mx, 1, 0, k[1]); k++;
        if (mx + 1 < 2048) begin one_req(mx + 1, 1, 0, k[0]); k++; end
      end
    end
    set_cfg(25000, 800, 525, 0);
    repeat (40) @(negedge clk);
    one_req(mn, 1, 5, 0);
    one_req(mx, 1, 12, 1);
    set_cfg(9000, 800, 50, 0);
    repeat (40) @(negedge clk);
    ctag = "R10";
    set_cfg(148500, 37, 525, 0);
    ctag = "R10";
    one_req(mn, 0, 0, 0);
    set_cfg(9000, 800, 3, 1);
    one_req(0, 0, 0, 0);
    set_cfg(25000, 2000, 1000, 1);
    ctag = "R10";
    one_req(mx + 1, 0, 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule